// File: doc/BRIEF.md
# Stack Pointer Unit with Overflow and Underflow Limit Checking

This block owns the pointer of a system stack kept in on-chip RAM, up to 1024 bytes. The stack grows toward lower addresses in 16-bit words. A push first moves the pointer down by two bytes and stores the word at the new address. A pop reads the word at the current address and then moves the pointer up by two bytes. The block drives the RAM port itself: address, write strobe, read strobe and write data. A popped word is passed straight from the RAM read data to the pop data output.

Software can load the pointer and two limit registers. One limit guards against running off the low end of the stack. The other guards against popping past its top. Every push is checked against the low limit and every pop against the high limit, with no extra request needed. A violation raises its own sticky trap request, which stays up until its own clear input is pulsed. The pointer move always completes, even when it raises a trap. Loading the pointer directly is never checked. Routing the traps to a handler is left to the surrounding processor.

Top module: `stack_guard`

## Requirements
- R1: While reset is held and after it is released, the pointer reads 0, both traps read 0, and neither RAM strobe is active. The low limit resets to 0 and the high limit to 1022.
- R2: A push drives `mem_we_o` high in the same cycle, with `mem_addr_o` equal to the pointer minus 2 (modulo 1024) and `mem_wdata_o` equal to `push_data_i`. The pointer holds that value from the next cycle on.
- R3: A pop drives `mem_re_o` high in the same cycle with `mem_addr_o` equal to the pointer, and `pop_data_o` equals `mem_rdata_i`. The pointer is 2 higher (modulo 1024) from the next cycle on.
- R4: A push whose new pointer, taken as a signed value before wrapping, is strictly below the low limit sets `ovf_trap_o` from the next cycle. A new pointer equal to the limit does not set it.
- R5: A pop whose new pointer, taken before wrapping, is strictly above the high limit sets `unf_trap_o` from the next cycle. A new pointer equal to the limit does not set it.
- R6: Each trap stays set until its own clear input is high for a cycle. Clearing one trap leaves the other unchanged. A new violation in the same cycle as a clear leaves the trap set. The pointer update completes whether or not a trap is raised.
- R7: When `sp_wr_i` is high, the pointer takes `reg_wdata_i` with bit 0 cleared in the next cycle. No limit check is made and no trap is raised. Any push or pop in the same cycle is dropped, with no RAM strobe.
- R8: Bit 0 of the pointer is always 0.
- R9: A push and a pop in the same cycle act as a push alone. The two RAM strobes are never active together.
- R10: A push from pointer 0 wraps the pointer to 1022 and always sets the overflow trap. A pop from pointer 1022 wraps it to 0 and always sets the underflow trap.
- R11: A limit write takes effect for every stack access from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 16 | Word to push |
| pop_data_o | output | 16 | Popped word (RAM read data passed through) |
| sp_wr_i | input | 1 | Load the pointer from `reg_wdata_i` |
| ovf_lim_wr_i | input | 1 | Load the low (overflow) limit |
| unf_lim_wr_i | input | 1 | Load the high (underflow) limit |
| reg_wdata_i | input | 10 | Write data for the pointer and the limits |
| ovf_clr_i | input | 1 | Clear the overflow trap |
| unf_clr_i | input | 1 | Clear the underflow trap |
| mem_addr_o | output | 10 | RAM byte address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data |
| sp_o | output | 10 | Current stack pointer |
| ovf_trap_o | output | 1 | Sticky overflow trap request |
| unf_trap_o | output | 1 | Sticky underflow trap request |

## Verification
A burst of pushes followed by as many pops checks write addresses against last-in-first-out read data. It also lands the pointer exactly on each limit, which separates a strict comparison from an inclusive one. Single steps across each limit, run with and without a clear in the same cycle, separate sticky, set-wins and per-trap clearing. Collisions of push with pop and of a pointer load with a push check the priority order. Steps that wrap at address 0 and at 1022 separate a check on the unwrapped result from one on the wrapped pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_LOAD = 2'd3
  } stk_op_e;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W:0]   dec_ext,
  output logic [ADDR_W:0]   inc_ext
);

  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(2);

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_d;
  logic              sp_en;

  assign dec_ext = {1'b0, sp_q} - STEP;
  assign inc_ext = {1'b0, sp_q} + STEP;

  always_comb begin
    sp_en = 1'b1;
    sp_d  = sp_q;
    unique case (op)
      STK_PUSH: sp_d = dec_ext[ADDR_W-1:0];
      STK_POP:  sp_d = inc_ext[ADDR_W-1:0];
      STK_LOAD: sp_d = {load_val[ADDR_W-1:1], 1'b0};
      default:  sp_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp = sp_q;

  AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q[0] == 1'b0) else $error("pointer odd"); // R8

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    op == STK_PUSH |=> sp_q == ADDR_W'($past(sp_q) - ADDR_W'(2))) else $error("push step"); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    op == STK_POP |=> sp_q == ADDR_W'($past(sp_q) + ADDR_W'(2))) else $error("pop step"); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    op == STK_LOAD |=> sp_q[ADDR_W-1:1] == $past(load_val[ADDR_W-1:1])) else $error("load"); // R7

endmodule

// File: rtl/stk_limit_reg.sv
module stk_limit_reg #(
  parameter int              ADDR_W  = 10,
  parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_val,
  output logic [ADDR_W-1:0] limit
);

  logic [ADDR_W-1:0] lim_q;
  logic [ADDR_W-1:0] lim_d;

  always_comb begin
    lim_d = lim_q;
    if (wr_en) begin
      lim_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= RST_VAL;
    end else begin
      lim_q <= lim_d;
    end
  end

  assign limit = lim_q;

  AST_LIMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lim_q == $past(wr_val)) else $error("limit write"); // R11

endmodule

// File: rtl/stk_trap_flag.sv
module stk_trap_flag #(
  parameter int ADDR_W      = 10,
  parameter bit CHECK_BELOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W:0]   cand,
  input  logic [ADDR_W-1:0] limit,
  input  logic              clr,
  output logic              flag
);

  logic hit;
  logic flag_q;
  logic flag_d;

  generate
    if (CHECK_BELOW) begin : g_below
      assign hit = fire && (cand[ADDR_W] || (cand[ADDR_W-1:0] < limit));
    end else begin : g_above
      assign hit = fire && (cand > {1'b0, limit});
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (hit) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_TRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q) else $error("trap not set"); // R4 R5

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q) else $error("trap dropped"); // R6

  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag_q) else $error("trap not cleared"); // R6

endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stk_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              sp_wr_i,
  input  logic              ovf_lim_wr_i,
  input  logic              unf_lim_wr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              ovf_clr_i,
  input  logic              unf_clr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ovf_trap_o,
  output logic              unf_trap_o
);

  localparam logic [ADDR_W-1:0] HI_LIM_RST = ADDR_W'((1 << ADDR_W) - 2);

  logic              rst_sync_n;
  stk_op_e           op;
  logic [ADDR_W-1:0] sp;
  logic [ADDR_W:0]   dec_ext;
  logic [ADDR_W:0]   inc_ext;
  logic [ADDR_W-1:0] lo_lim;
  logic [ADDR_W-1:0] hi_lim;
  logic              is_push;
  logic              is_pop;

  stk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Priority: pointer load, then push, then pop.
  always_comb begin
    if (sp_wr_i) begin
      op = STK_LOAD;
    end else if (push_i) begin
      op = STK_PUSH;
    end else if (pop_i) begin
      op = STK_POP;
    end else begin
      op = STK_IDLE;
    end
  end

  assign is_push = (op == STK_PUSH);
  assign is_pop  = (op == STK_POP);

  stk_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .load_val (reg_wdata_i),
    .sp       (sp),
    .dec_ext  (dec_ext),
    .inc_ext  (inc_ext)
  );

  stk_limit_reg #(.ADDR_W(ADDR_W), .RST_VAL('0)) u_lo_lim (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (ovf_lim_wr_i),
    .wr_val (reg_wdata_i),
    .limit  (lo_lim)
  );

  stk_limit_reg #(.ADDR_W(ADDR_W), .RST_VAL(HI_LIM_RST)) u_hi_lim (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (unf_lim_wr_i),
    .wr_val (reg_wdata_i),
    .limit  (hi_lim)
  );

  stk_trap_flag #(.ADDR_W(ADDR_W), .CHECK_BELOW(1'b1)) u_ovf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (is_push),
    .cand  (dec_ext),
    .limit (lo_lim),
    .clr   (ovf_clr_i),
    .flag  (ovf_trap_o)
  );

  stk_trap_flag #(.ADDR_W(ADDR_W), .CHECK_BELOW(1'b0)) u_unf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (is_pop),
    .cand  (inc_ext),
    .limit (hi_lim),
    .clr   (unf_clr_i),
    .flag  (unf_trap_o)
  );

  assign mem_we_o    = is_push;
  assign mem_re_o    = is_pop;
  assign mem_addr_o  = is_push ? dec_ext[ADDR_W-1:0] : sp;
  assign mem_wdata_o = push_data_i;
  assign pop_data_o  = mem_rdata_i;
  assign sp_o        = sp;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_we_o && mem_re_o)) else $error("both strobes"); // R9

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sp_wr_i |-> !mem_we_o && !mem_re_o) else $error("load with strobe"); // R7

  AST_LOAD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sp_wr_i && !ovf_trap_o |=> !ovf_trap_o) else $error("load raised overflow"); // R7

  AST_LOAD_NO_UNF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sp_wr_i && !unf_trap_o |=> !unf_trap_o) else $error("load raised underflow"); // R7

endmodule

// File: tb/stack_guard_tb.sv
`timescale 1ns/1ps
module stack_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, sp_wr_i = 1'b0;
  logic        ovf_lim_wr_i = 1'b0, unf_lim_wr_i = 1'b0;
  logic        ovf_clr_i = 1'b0, unf_clr_i = 1'b0;
  logic [15:0] push_data_i = '0;
  logic [9:0]  reg_wdata_i = '0;
  logic [15:0] pop_data_o, mem_wdata_o, mem_rdata_i;
  logic [9:0]  mem_addr_o, sp_o;
  logic        mem_we_o, mem_re_o, ovf_trap_o, unf_trap_o;

  logic [15:0] ram [0:511];
  logic [15:0] exp_mem [0:511];

  int  n_vec = 0, n_bad = 0;
  int  e_sp = 0, e_lo = 0, e_hi = 1022;
  bit  e_ov = 0, e_un = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  stack_guard u_dut (
    .clk (clk), .rst_n (rst_n),
    .push_i (push_i), .pop_i (pop_i), .push_data_i (push_data_i),
    .pop_data_o (pop_data_o), .sp_wr_i (sp_wr_i),
    .ovf_lim_wr_i (ovf_lim_wr_i), .unf_lim_wr_i (unf_lim_wr_i),
    .reg_wdata_i (reg_wdata_i), .ovf_clr_i (ovf_clr_i), .unf_clr_i (unf_clr_i),
    .mem_addr_o (mem_addr_o), .mem_we_o (mem_we_o), .mem_re_o (mem_re_o),
    .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i),
    .sp_o (sp_o), .ovf_trap_o (ovf_trap_o), .unf_trap_o (unf_trap_o)
  );

  // RAM model: asynchronous read, write on the clock edge
  always @(posedge clk) if (mem_we_o) ram[mem_addr_o[9:1]] <= mem_wdata_o;
  assign mem_rdata_i = ram[mem_addr_o[9:1]];

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " sp"}, int'(sp_o), e_sp);
    chk({req, " ovf"}, int'(ovf_trap_o), int'(e_ov));
    chk({req, " unf"}, int'(unf_trap_o), int'(e_un));
  endtask

  // One cycle of stimulus; checks strobes in the cycle and state after it.
  task automatic access(input bit pu, input bit po, input bit wr, input int wval,
                        input logic [15:0] d, input bit co, input bit cu,
                        input string req);
    bit do_pu, do_po, hit_o, hit_u;
    int n;
    @(negedge clk);
    push_i = pu; pop_i = po; sp_wr_i = wr; reg_wdata_i = 10'(wval);
    push_data_i = d; ovf_clr_i = co; unf_clr_i = cu;
    #1;
    do_pu = pu && !wr;
    do_po = po && !pu && !wr;
    chk({req, " we"}, int'(mem_we_o), int'(do_pu));
    chk({req, " re"}, int'(mem_re_o), int'(do_po));
    hit_o = 0; hit_u = 0;
    if (wr) begin
      e_sp = wval & 'h3FE;
    end else if (do_pu) begin
      n = e_sp - 2;
      hit_o = (n < e_lo);
      e_sp = n & 'h3FF;
      chk({req, " push addr"}, int'(mem_addr_o), e_sp);
      chk({req, " push data"}, int'(mem_wdata_o), int'(d));
      exp_mem[e_sp >> 1] = d;
    end else if (do_po) begin
      chk({req, " pop addr"}, int'(mem_addr_o), e_sp);
      chk({req, " pop data"}, int'(pop_data_o), int'(exp_mem[e_sp >> 1]));
      n = e_sp + 2;
      hit_u = (n > e_hi);
      e_sp = n & 'h3FF;
    end
    e_ov = (e_ov && !co) || hit_o;
    e_un = (e_un && !cu) || hit_u;
    @(negedge clk);
    push_i = 0; pop_i = 0; sp_wr_i = 0; ovf_clr_i = 0; unf_clr_i = 0;
    #1;
    chk_state(req);
  endtask

  task automatic write_limit(input bit hi, input int val);
    @(negedge clk);
    reg_wdata_i = 10'(val);
    if (hi) unf_lim_wr_i = 1; else ovf_lim_wr_i = 1;
    @(negedge clk);
    unf_lim_wr_i = 0; ovf_lim_wr_i = 0;
    if (hi) e_hi = val; else e_lo = val;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    #1;
    chk_state("R1 in reset");
    chk("R1 we", int'(mem_we_o), 0);
    chk("R1 re", int'(mem_re_o), 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk_state("R1 after release");
  endtask

  task automatic t_reset_limits;
    // R1 reset limits: push from 4 to 2 is above 0; pop from 1020 to 1022 equals 1022
    access(0, 0, 1, 4, 0, 0, 0, "R1 load");
    access(1, 0, 0, 0, 16'h1111, 0, 0, "R1 low limit reset");
    access(0, 0, 1, 1020, 0, 0, 0, "R1 load hi");
    access(0, 1, 0, 0, 0, 0, 0, "R1 high limit reset");
  endtask

  task automatic t_load_align;
    write_limit(0, 'h100);
    write_limit(1, 'h200);
    access(0, 0, 1, 'h201, 0, 0, 0, "R8 R7 odd load");
  endtask

  task automatic t_push_pop;
    access(1, 0, 0, 0, 16'hA001, 0, 0, "R2 push 1");
    access(1, 0, 0, 0, 16'hB002, 0, 0, "R2 push 2");
    access(1, 0, 0, 0, 16'hC003, 0, 0, "R2 push 3");
    access(0, 1, 0, 0, 0, 0, 0, "R3 pop 1");
    access(0, 1, 0, 0, 0, 0, 0, "R3 pop 2");
    access(0, 1, 0, 0, 0, 0, 0, "R3 R5 pop to limit");
  endtask

  task automatic t_underflow;
    access(0, 1, 0, 0, 0, 0, 0, "R5 pop past limit");
    access(1, 0, 0, 0, 16'h5555, 0, 0, "R6 unf sticky");
    access(0, 0, 0, 0, 0, 1, 0, "R6 ovf clear leaves unf");
    access(0, 0, 0, 0, 0, 0, 1, "R6 unf clear");
  endtask

  task automatic t_overflow;
    access(0, 0, 1, 'h102, 0, 0, 0, "R4 load");
    access(1, 0, 0, 0, 16'h0102, 0, 0, "R4 push to limit");
    access(1, 0, 0, 0, 16'h0103, 0, 0, "R4 push below limit");
    access(1, 0, 0, 0, 16'h0104, 1, 0, "R6 set wins over clear");
    access(0, 0, 0, 0, 0, 1, 0, "R6 ovf clear");
  endtask

  task automatic t_limit_change;
    write_limit(0, 'h080);
    access(1, 0, 0, 0, 16'h0A0A, 0, 0, "R11 new low limit");
    write_limit(1, 'h0F0);
    access(0, 1, 0, 0, 0, 0, 0, "R11 new high limit");
    access(0, 0, 0, 0, 0, 0, 1, "R11 clear");
    write_limit(1, 'h200);
  endtask

  task automatic t_collide;
    access(1, 1, 0, 0, 16'h7E7E, 0, 0, "R9 push with pop");
    access(1, 1, 1, 'h010, 16'h6666, 0, 0, "R7 load beats push");
    access(0, 1, 1, 'h3FF, 0, 0, 0, "R7 load beats pop");
  endtask

  task automatic t_wrap;
    access(0, 0, 1, 0, 0, 0, 0, "R10 load 0");
    access(1, 0, 0, 0, 16'hFACE, 0, 0, "R10 push wraps");
    access(0, 0, 0, 0, 0, 1, 0, "R10 clear");
    write_limit(1, 'h3FE);
    access(0, 1, 0, 0, 0, 0, 0, "R10 pop wraps");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reset_limits();
    t_load_align();
    t_push_pop();
    t_underflow();
    t_overflow();
    t_limit_change();
    t_collide();
    t_wrap();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule